// File: doc/BRIEF.md
# Paged Address Bank Decoder

This block turns a paged memory request into a routed access. An 8-bit page and a 16-bit index are joined into a 24-bit address. The address is then sorted into one of four groups: on-chip memory, a reserved on-chip hole, one of four external banks, or I/O space. I/O space is either internal peripherals or an external select. Each external access drives one select strobe. The strobe stays active while a per-space wait counter runs down, and the request is acknowledged after the strobe is released. On-chip and internal-peripheral accesses are acknowledged in the cycle after acceptance. Accesses to reserved regions are acknowledged with an error flag.

Three programmable boundary registers split pages 1 to 254 among the external banks. Each boundary holds the first page of bank 1, 2 or 3. Pages 0 and 255 always stay on-chip. Each of the five external spaces (four banks plus external I/O) has its own timing register. It holds a read wait count, a write wait count and a strobe polarity bit. A small write port loads all of these registers. A write that would leave the boundaries out of order is refused and flagged.

Top module: `pgbank_decoder`

## Requirements
- R1: The composed address on `addr_out` is `{req_page, req_index}` from the cycle after acceptance. In page 0, the index windows 0x0000–0x0FFF and 0x8000–0x8FFF are on-chip. Such an access is acknowledged one cycle after acceptance, without error and without any strobe.
- R2: In page 0xFF, index 0x0000–0x0FFF is on-chip and the rest of the page is reserved. No access to page 0xFF ever drives a bank strobe.
- R3: Any page-0 index outside the two on-chip windows is reserved. It is acknowledged one cycle after acceptance with `ack_err` high, and no strobe is driven.
- R4: After reset the boundaries are 64, 128 and 192. Pages 1–63 go to bank 0, 64–127 to bank 1, 128–191 to bank 2 and 192–254 to bank 3. Bank k drives `bank_strobe[k]`.
- R5: After reset every strobe is inactive, and the default polarity is active-low (idle level 1). At most one strobe is active in any cycle.
- R6: With a selected wait count N, the strobe is active for N+1 cycles and `ack` rises in the cycle after the strobe drops. That is N+2 cycles after acceptance. Writes use the write count and reads use the read count, both latched at acceptance.
- R7: Timing register bit 8 set makes that space's strobe active-high. This also changes its idle level immediately.
- R8: Boundary registers sit at config addresses 0, 1 and 2 and hold the first page of banks 1, 2 and 3. A page's bank is the number of boundaries less than or equal to the page. Equal boundaries leave a bank empty. New values apply to the next access.
- R9: A config write is ignored if it would set a boundary to 0, would break the order b0 ≤ b1 ≤ b2, or targets an unmapped address. Only addresses 0–2 and 8–12 are mapped. `cfg_err` is high for one cycle after an ignored write, and only then.
- R10: I/O requests use only the page. Pages 0–31 raise `io_int_sel` together with `ack` one cycle after acceptance, with no strobe. Pages 32–255 drive `io_strobe` using timing register 12 as in R6.
- R11: `ack` is a single-cycle pulse. A request is taken only while the block is idle, and the requester holds it until `ack`.
- R12: Timing registers sit at config address 8+k, where k is 0–3 for banks 0–3 and 4 for external I/O. Bits [3:0] hold the read wait, bits [7:4] the write wait, and bit [8] the polarity. All fields reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until ack |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_io | input | 1 | 1 selects I/O space |
| req_page | input | 8 | Page (upper address bits) |
| req_index | input | 16 | Index within page |
| ack | output | 1 | Access complete, one-cycle pulse |
| ack_err | output | 1 | Access hit a reserved region, valid with ack |
| io_int_sel | output | 1 | Internal peripheral selected, valid with ack |
| addr_out | output | 24 | Composed address of the accepted request |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 4 | Config register address |
| cfg_wdata | input | 16 | Config write data |
| cfg_err | output | 1 | Previous config write was refused |
| bank_strobe | output | 4 | Per-bank select strobes, polarity per bank |
| io_strobe | output | 1 | External I/O select strobe |

## Verification
The assertions assume a well-behaved requester. It keeps `req_valid` and the request fields steady from the cycle it raises them until it sees `ack`, and it drops `req_valid` in that same cycle. This means no second request reaches the decoder while the acknowledge state drains. The countdown and single-select properties also rely on timing writes being latched at acceptance, so reprogramming a count mid-access cannot disturb them. The stimulus drives every request at a falling edge, watches for `ack`, and releases the request before the next rising edge. Configuration is changed only between accesses.

// File: rtl/pgbank_pkg.sv
package pgbank_pkg;
  localparam int PAGE_W  = 8;
  localparam int IDX_W   = 16;
  localparam int ADDR_W  = PAGE_W + IDX_W;
  localparam int NBANK   = 4;
  localparam int NBND    = NBANK - 1;
  localparam int NSLOT   = NBANK + 1;
  localparam int IO_SLOT = NBANK;
  localparam int BANK_W  = $clog2(NBANK);
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int CFG_AW  = 4;
  localparam int CFG_DW  = 16;
  localparam int TIM_BASE = 8;

  localparam logic [PAGE_W-1:0] TOP_PAGE    = '1;
  localparam logic [IDX_W-1:0]  ONCHIP_SPAN = 16'h1000;
  localparam logic [IDX_W-1:0]  RAM16_BASE  = 16'h8000;

  typedef logic [PAGE_W-1:0]            page_t;
  typedef logic [NBND-1:0][PAGE_W-1:0]  bounds_t;

  typedef enum logic [2:0] {
    TGT_ONCHIP,
    TGT_RESERVED,
    TGT_BANK,
    TGT_IO_INT,
    TGT_IO_EXT
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [BANK_W-1:0] bank;
  } route_t;

  // bank number = how many boundaries lie at or below the page
  function automatic logic [BANK_W-1:0] f_bank_of(page_t pg, bounds_t b);
    logic [BANK_W-1:0] n;
    n = '0;
    for (int i = 0; i < NBND; i++)
      if (pg >= b[i]) n = n + 1'b1;
    return n;
  endfunction

  // boundaries legal: first non-zero, whole set non-decreasing
  function automatic logic f_ordered(bounds_t b);
    logic ok;
    ok = (b[0] != '0);
    for (int i = 1; i < NBND; i++)
      if (b[i] < b[i-1]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic f_in_window(logic [IDX_W-1:0] a, logic [IDX_W-1:0] base);
    return (a >= base) && (a < base + ONCHIP_SPAN);
  endfunction
endpackage

// File: rtl/pgbank_classify.sv
module pgbank_classify import pgbank_pkg::*; #(
  parameter int IO_INT_PAGES = 32
) (
  input  logic             is_io,
  input  page_t            page,
  input  logic [IDX_W-1:0] index,
  input  bounds_t          bounds,
  output route_t           route
);
  localparam page_t IO_LIM = page_t'(IO_INT_PAGES);

  always_comb begin
    route.tgt  = TGT_RESERVED;
    route.bank = '0;
    if (is_io) begin
      route.tgt = (page < IO_LIM) ? TGT_IO_INT : TGT_IO_EXT;
    end else if (page == '0) begin
      if (f_in_window(index, '0) || f_in_window(index, RAM16_BASE))
        route.tgt = TGT_ONCHIP;
    end else if (page == TOP_PAGE) begin
      if (f_in_window(index, '0))
        route.tgt = TGT_ONCHIP;
    end else begin
      route.tgt  = TGT_BANK;
      route.bank = f_bank_of(page, bounds);
    end
  end
endmodule

// File: rtl/pgbank_cfg.sv
module pgbank_cfg import pgbank_pkg::*; #(
  parameter int WAIT_W = 4,
  parameter logic [NBND*PAGE_W-1:0] DEF_BOUNDS = {8'd192, 8'd128, 8'd64}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [CFG_DW-1:0]             cfg_wdata,
  output bounds_t                       bounds,
  output logic [NSLOT-1:0][WAIT_W-1:0]  rd_wait,
  output logic [NSLOT-1:0][WAIT_W-1:0]  wr_wait,
  output logic [NSLOT-1:0]              pol_hi,
  output logic                          cfg_err
);
  localparam logic [CFG_AW-1:0] BND_HI = CFG_AW'(NBND);
  localparam logic [CFG_AW-1:0] TIM_LO = CFG_AW'(TIM_BASE);
  localparam logic [CFG_AW-1:0] TIM_HI = CFG_AW'(TIM_BASE + NSLOT);
  localparam int POL_BIT = 2 * WAIT_W;

  logic    bnd_sel, tim_sel, bnd_ok, bnd_wr, rej_wr;
  bounds_t cand;
  logic    unused_wdata;

  assign unused_wdata = ^cfg_wdata[CFG_DW-1:POL_BIT+1];

  assign bnd_sel = (cfg_addr < BND_HI);
  assign tim_sel = (cfg_addr >= TIM_LO) && (cfg_addr < TIM_HI);

  always_comb begin
    cand = bounds;
    for (int i = 0; i < NBND; i++)
      if (cfg_addr == CFG_AW'(i)) cand[i] = cfg_wdata[PAGE_W-1:0];
  end

  assign bnd_ok = f_ordered(cand);
  assign bnd_wr = cfg_we && bnd_sel && bnd_ok;
  assign rej_wr = cfg_we && !(tim_sel || (bnd_sel && bnd_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bounds  <= bounds_t'(DEF_BOUNDS);
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= rej_wr;
      if (bnd_wr) bounds <= cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_wait <= '0;
      wr_wait <= '0;
      pol_hi  <= '0;
    end else if (cfg_we && tim_sel) begin
      for (int k = 0; k < NSLOT; k++) begin
        if (cfg_addr == CFG_AW'(TIM_BASE + k)) begin
          rd_wait[k] <= cfg_wdata[WAIT_W-1:0];
          wr_wait[k] <= cfg_wdata[2*WAIT_W-1:WAIT_W];
          pol_hi[k]  <= cfg_wdata[POL_BIT];
        end
      end
    end
  end

  a_r9_bounds_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    f_ordered(bounds));
  a_r9_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rej_wr |=> (bounds == $past(bounds)));
  a_r9_flag_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));
endmodule

// File: rtl/pgbank_access.sv
module pgbank_access import pgbank_pkg::*; #(
  parameter int WAIT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  route_t                        route,
  input  logic [NSLOT-1:0][WAIT_W-1:0]  rd_wait,
  input  logic [NSLOT-1:0][WAIT_W-1:0]  wr_wait,
  output logic                          accept,
  output logic [NSLOT-1:0]              sel,
  output logic                          ack,
  output logic                          ack_err,
  output logic                          io_int_sel
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK} st_e;

  st_e               st;
  logic [WAIT_W-1:0] cnt;
  logic              is_ext, cnt_zero;
  logic [SLOT_W-1:0] slot_idx;
  logic [WAIT_W-1:0] load_val;
  logic [NSLOT-1:0]  slot_hot;

  assign accept   = (st == ST_IDLE) && req_valid;
  assign is_ext   = (route.tgt == TGT_BANK) || (route.tgt == TGT_IO_EXT);
  assign slot_idx = (route.tgt == TGT_IO_EXT) ? SLOT_W'(IO_SLOT) : SLOT_W'(route.bank);
  assign load_val = req_write ? wr_wait[slot_idx] : rd_wait[slot_idx];
  assign slot_hot = NSLOT'(1) << slot_idx;
  assign cnt_zero = (cnt == '0);
  assign ack      = (st == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      sel        <= '0;
      ack_err    <= 1'b0;
      io_int_sel <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          if (is_ext) begin
            st  <= ST_WAIT;
            sel <= slot_hot;
            cnt <= load_val;
          end else begin
            st         <= ST_ACK;
            ack_err    <= (route.tgt == TGT_RESERVED);
            io_int_sel <= (route.tgt == TGT_IO_INT);
          end
        end
        ST_WAIT: begin
          if (cnt_zero) begin
            st  <= ST_ACK;
            sel <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st         <= ST_IDLE;
          ack_err    <= 1'b0;
          io_int_sel <= 1'b0;
        end
      endcase
    end
  end

  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  a_r6_select_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> (sel != '0));
  a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !cnt_zero) |=> (st == ST_WAIT && cnt == $past(cnt) - 1'b1));
  a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r3_err_without_select: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (ack && sel == '0));
  a_r10_int_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    io_int_sel |-> (ack && !ack_err && sel == '0));
endmodule

// File: rtl/pgbank_decoder.sv
module pgbank_decoder import pgbank_pkg::*; #(
  parameter int WAIT_W       = 4,
  parameter int IO_INT_PAGES = 32,
  parameter logic [NBND*PAGE_W-1:0] DEF_BOUNDS = {8'd192, 8'd128, 8'd64}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [7:0]        req_page,
  input  logic [15:0]       req_index,
  output logic              ack,
  output logic              ack_err,
  output logic              io_int_sel,
  output logic [23:0]       addr_out,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              cfg_err,
  output logic [3:0]        bank_strobe,
  output logic              io_strobe
);
  bounds_t                       bounds;
  logic [NSLOT-1:0][WAIT_W-1:0]  rd_wait, wr_wait;
  logic [NSLOT-1:0]              pol_hi, sel;
  route_t                        route;
  logic                          accept;

  pgbank_cfg #(.WAIT_W(WAIT_W), .DEF_BOUNDS(DEF_BOUNDS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bounds(bounds), .rd_wait(rd_wait),
    .wr_wait(wr_wait), .pol_hi(pol_hi), .cfg_err(cfg_err)
  );

  pgbank_classify #(.IO_INT_PAGES(IO_INT_PAGES)) u_cls (
    .is_io(req_io), .page(req_page), .index(req_index),
    .bounds(bounds), .route(route)
  );

  pgbank_access #(.WAIT_W(WAIT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .route(route), .rd_wait(rd_wait), .wr_wait(wr_wait), .accept(accept),
    .sel(sel), .ack(ack), .ack_err(ack_err), .io_int_sel(io_int_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_out <= '0;
    else if (accept) addr_out <= {req_page, req_index};
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_strobe
    assign bank_strobe[k] = pol_hi[k] ? sel[k] : ~sel[k];
  end
  assign io_strobe = pol_hi[IO_SLOT] ? sel[IO_SLOT] : ~sel[IO_SLOT];

  a_r2_edge_pages_onchip: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_io && (req_page == '0 || req_page == TOP_PAGE))
      |-> (route.tgt != TGT_BANK));
  a_r1_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (addr_out == {$past(req_page), $past(req_index)}));
endmodule

// File: tb/tb_pgbank_decoder.sv
module tb_pgbank_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_io = 0;
  logic [7:0]  req_page = '0;
  logic [15:0] req_index = '0;
  logic        ack, ack_err, io_int_sel, cfg_err, io_strobe;
  logic [23:0] addr_out;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  bank_strobe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgbank_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_page(req_page), .req_index(req_index),
    .ack(ack), .ack_err(ack_err), .io_int_sel(io_int_sel), .addr_out(addr_out),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_err(cfg_err), .bank_strobe(bank_strobe), .io_strobe(io_strobe)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_rd[5], m_wr[5];
  bit m_pol[5];

  // vector: {io, write, page, index, expected code}
  // codes: 0 on-chip, 1 reserved, 2..5 bank 0..3, 6 external I/O, 7 internal I/O
  localparam int NVEC = 24;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0,1'b0,8'h00,16'h0000,3'd0}, {1'b0,1'b1,8'h00,16'h0FFF,3'd0},
    {1'b0,1'b0,8'h00,16'h1000,3'd1}, {1'b0,1'b1,8'h00,16'h7FFF,3'd1},
    {1'b0,1'b0,8'h00,16'h8000,3'd0}, {1'b0,1'b0,8'h00,16'h8FFF,3'd0},
    {1'b0,1'b0,8'h00,16'h9000,3'd1}, {1'b0,1'b0,8'h00,16'hFFFF,3'd1},
    {1'b0,1'b0,8'hFF,16'h0000,3'd0}, {1'b0,1'b1,8'hFF,16'h0FFF,3'd0},
    {1'b0,1'b0,8'hFF,16'h1000,3'd1}, {1'b0,1'b0,8'h01,16'h1234,3'd2},
    {1'b0,1'b1,8'h3F,16'hFFFF,3'd2}, {1'b0,1'b0,8'h40,16'h0000,3'd3},
    {1'b0,1'b1,8'h7F,16'h0042,3'd3}, {1'b0,1'b0,8'h80,16'h0001,3'd4},
    {1'b0,1'b1,8'hBF,16'h8000,3'd4}, {1'b0,1'b0,8'hC0,16'h0000,3'd5},
    {1'b0,1'b1,8'hFE,16'hFFFF,3'd5}, {1'b1,1'b0,8'h00,16'h0000,3'd7},
    {1'b1,1'b1,8'h1F,16'h03FF,3'd7}, {1'b1,1'b1,8'h20,16'h0000,3'd6},
    {1'b1,1'b0,8'hFF,16'h03FF,3'd6}, {1'b0,1'b0,8'hFE,16'h0000,3'd5}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int code, logic [7:0] pg);
    if (code <= 1) return (pg == 8'hFF) ? "R2" : ((code == 0) ? "R1" : "R3");
    if (code <= 5) return "R4";
    return "R10";
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d,
                           input bit exp_err, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_err == exp_err, tag, "cfg_err", cfg_err, exp_err);
    if (!exp_err && a >= 4'd8) begin
      m_rd[a-8]  = int'(d[3:0]);
      m_wr[a-8]  = int'(d[7:4]);
      m_pol[a-8] = d[8];
    end
  endtask

  task automatic do_access(input bit io, input bit wr, input logic [7:0] pg,
                           input logic [15:0] ix, input int exp_code, input string tag);
    int lat = 0, scyc = 0, code, slot, ew, exp_lat, exp_scyc;
    logic [4:0] mask = '0, now;
    bit got_ack = 0, got_err = 0, got_int = 0;
    logic [23:0] got_addr = '0;
    @(negedge clk);
    req_io = io; req_write = wr; req_page = pg; req_index = ix; req_valid = 1;
    while (!got_ack && lat < 64) begin
      @(negedge clk);
      lat++;
      for (int k = 0; k < 4; k++) now[k] = (bank_strobe[k] == m_pol[k]);
      now[4] = (io_strobe == m_pol[4]);
      mask |= now;
      if (now != '0) scyc++;
      if (ack) begin
        got_ack = 1; got_err = ack_err; got_int = io_int_sel; got_addr = addr_out;
      end
    end
    req_valid = 0;
    if ($countones(mask) > 1)  code = 15;
    else if (got_err)          code = 1;
    else if (mask[4])          code = 6;
    else if (mask != '0)       begin code = 2; for (int k = 0; k < 4; k++) if (mask[k]) code = 2 + k; end
    else if (got_int)          code = 7;
    else                       code = 0;
    chk(code == exp_code, tag, "route code", code, exp_code);
    slot = (exp_code == 6) ? 4 : exp_code - 2;
    if (exp_code >= 2 && exp_code <= 6) begin
      ew = wr ? m_wr[slot] : m_rd[slot];
      exp_lat = ew + 2; exp_scyc = ew + 1;
    end else begin
      exp_lat = 1; exp_scyc = 0;
    end
    chk(lat == exp_lat, "R6", "ack latency", lat, exp_lat);
    chk(scyc == exp_scyc, "R6", "strobe cycles", scyc, exp_scyc);
    chk(got_addr == {pg, ix}, "R1", "addr_out", got_addr, {pg, ix});
    @(negedge clk);
    chk(ack == 1'b0, "R11", "ack pulse width", ack, 0);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin m_rd[k] = 0; m_wr[k] = 0; m_pol[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ack == 0 && ack_err == 0 && io_int_sel == 0, "R11", "reset ack", ack, 0);
    chk(bank_strobe == 4'hF && io_strobe == 1'b1, "R5", "reset strobes",
        {bank_strobe, io_strobe}, 5'h1F);
    chk(cfg_err == 0 && addr_out == '0, "R5", "reset cfg_err/addr", cfg_err, 0);

    // R12 timing fields: [3:0] read, [7:4] write, [8] polarity
    cfg_write(4'd8,  16'h012, 0, "R12");
    cfg_write(4'd9,  16'h030, 0, "R12");
    cfg_write(4'd10, 16'h001, 0, "R12");
    cfg_write(4'd11, 16'h004, 0, "R12");
    cfg_write(4'd12, 16'h012, 0, "R12");

    for (int v = 0; v < NVEC; v++)
      do_access(VEC[v][28], VEC[v][27], VEC[v][26:19], VEC[v][18:3],
                int'(VEC[v][2:0]), tag_of(int'(VEC[v][2:0]), VEC[v][26:19]));

    // R9 refused writes
    cfg_write(4'd0, 16'd200, 1, "R9");
    do_access(0, 0, 8'h70, 16'h0000, 3, "R9");
    cfg_write(4'd0, 16'd0, 1, "R9");
    cfg_write(4'd3, 16'd5, 1, "R9");
    cfg_write(4'd15, 16'h0001, 1, "R9");
    do_access(0, 0, 8'h40, 16'h0000, 3, "R9");

    // R8 reprogrammed boundaries
    cfg_write(4'd0, 16'd10, 0, "R8");
    do_access(0, 0, 8'h09, 16'h0000, 2, "R8");
    do_access(0, 1, 8'h0A, 16'h0000, 3, "R8");
    cfg_write(4'd2, 16'd255, 0, "R8");
    do_access(0, 0, 8'hFE, 16'h0000, 4, "R8");
    cfg_write(4'd1, 16'd10, 0, "R8");
    do_access(0, 0, 8'h0A, 16'h0000, 4, "R8");

    // R7 polarity
    cfg_write(4'd10, 16'h101, 0, "R7");
    chk(bank_strobe == 4'b1011, "R7", "idle level active-high", bank_strobe, 4'b1011);
    do_access(0, 1, 8'h20, 16'h0000, 4, "R7");
    do_access(0, 0, 8'h20, 16'h0000, 4, "R7");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule